// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers interrupt requests for a small 16-bit microcontroller and presents the most urgent one to the CPU. It has sixteen priority slots. The slot number is the priority, so slot 15 is the most urgent. Each slot owns one 16-bit vector word, and the word address follows directly from the slot: `0xFFE0 + 2 * slot`.

Slot 15 is the reset slot. Slot 14 is shared by three non-maskable causes: the reset/NMI pin, an oscillator fault and a flash access violation. The watchdog (in interval mode), the serial receiver and the serial transmitter own slots 10, 9 and 8. Every other slot takes a level request from an outside peripheral.

Software reaches two byte-wide registers over a simple register bus: an enable register and a flag register. The CPU sees three outputs: a request, the vector address and the winning slot index. It answers with a one-cycle acknowledge while the request is shown, and the acknowledge tidies up the acknowledged source.

The block has three reset inputs:
- a power-on reset;
- a reset from the external pin;
- a soft system reset.

They differ only in what happens to the watchdog flag.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After any reset the enable register (address 0) reads 0x00. The flag register (address 1) reads 0x82: the transmit flag (bit 7) and the oscillator-fault flag (bit 1) are set, and after power-on the watchdog flag (bit 0) is 0. The reset slot is pending, so `irq_req`=1, `irq_idx`=15 and `irq_vec`=0xFFFE, until it is acknowledged.
- R2: When one or more slots are pending, the highest-numbered pending slot wins and `irq_vec` = 0xFFE0 + 2 × `irq_idx`. With nothing pending, `irq_req` is 0.
- R3: Either of two events makes the reset slot 15 pending: a watchdog overflow while `wdt_rst_mode`=1, or a watchdog key violation in either mode. Acknowledging slot 15 clears it. An overflow while `wdt_rst_mode`=0 does not touch slot 15.
- R4: Slot 14 is pending when any of these holds, whatever the state of `gie`:
  - NMI flag (bit 4) and NMI enable (bit 4) are both set;
  - oscillator-fault flag (bit 1) and enable (bit 1) are both set;
  - `flash_viol` is high and the flash enable (bit 5) is set.
- R5: Acknowledging slot 14 clears the enable bit of each slot-14 source that was contributing at that moment. It leaves all other enable bits and all flags unchanged.
- R6: Only enable bits 7, 6, 5, 4, 1, 0 (mask 0xF3) and flag bits 7, 6, 4, 1, 0 (mask 0xD3) exist. The other bits read 0 and ignore writes. Any other address reads 0.
- R7: A one-cycle event pulse sets its flag:
  - `ser_tx_ev` sets bit 7;
  - `ser_rx_ev` sets bit 6;
  - `nmi_pin_ev` sets bit 4;
  - `osc_fault_ev` sets bit 1;
  - `wdt_ovf_ev` sets bit 0.
- R8: The watchdog flag (bit 0) is cleared only by `por_n` or `pinrst_n`. A soft reset through `rst_n` keeps its value.
- R9: Slot 10 is pending when the watchdog enable (bit 0) and flag (bit 0) are both set, but only while `wdt_rst_mode`=0. In reset mode the watchdog enable has no effect.
- R10: Slots 0–13 other than slot 14 are presented only while `gie`=1.
- R11: Acknowledging slot 10, 9 or 8 clears flag bit 0, 6 or 7 respectively. Acknowledging a peripheral slot changes no flag.
- R12: A software write to the flag register takes precedence over a hardware event that sets a flag in the same cycle.
- R13: Bits of `periph_req` drive slots 13, 12, 11 and 7–0 as level requests. Bits 15, 14, 10, 9 and 8 of `periph_req` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| pinrst_n | input | 1 | Reset from the external pin, synchronous, active low |
| rst_n | input | 1 | Soft system reset, synchronous, active low |
| bus_addr | input | 2 | Register select: 0 enable, 1 flag |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| gie | input | 1 | Global enable for maskable slots |
| wdt_rst_mode | input | 1 | 1: watchdog in reset mode, 0: interval mode |
| wdt_ovf_ev | input | 1 | Watchdog overflow pulse |
| wdt_key_ev | input | 1 | Watchdog key violation pulse |
| nmi_pin_ev | input | 1 | NMI pin edge pulse |
| osc_fault_ev | input | 1 | Oscillator fault pulse |
| flash_viol | input | 1 | Flash access violation level |
| ser_rx_ev | input | 1 | Serial receive complete pulse |
| ser_tx_ev | input | 1 | Serial transmit ready pulse |
| periph_req | input | 16 | Level requests, one bit per slot |
| irq_req | output | 1 | An interrupt is pending |
| irq_vec | output | 16 | Byte address of the winning vector word |
| irq_idx | output | 4 | Winning slot number |
| irq_ack | input | 1 | CPU acknowledges the shown slot |

## Verification
All requests are combinational from registered state.

A wrong flag or enable bit shows on `bus_rdata` in the same cycle it is read back. It also changes `irq_idx` and `irq_vec` on the edge right after the event or write that produced it.

A missed acknowledge action shows one cycle after `irq_ack`, in one of two ways:
- the same slot is still presented;
- a stale enable bit reads back.

The bench therefore checks readback and the arbitration outputs at the first falling edge after each stimulus.

// File: rtl/irq_vc_pkg.sv
// Shared constants of the interrupt vector controller.
// Assumes a 16-slot priority map and byte-wide control registers.
package irq_vc_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_SLOTS = 16;
    localparam int IDX_W     = $clog2(NUM_SLOTS);
    localparam int VEC_W     = 16;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'hFFE0;

    // Slot numbers (slot number equals priority)
    localparam int SLOT_RST = 15;
    localparam int SLOT_NMI = 14;
    localparam int SLOT_WDT = 10;
    localparam int SLOT_RX  = 9;
    localparam int SLOT_TX  = 8;
    localparam logic [NUM_SLOTS-1:0] PERIPH_MASK = 16'h38FF;

    // Bit positions shared by the enable and flag registers
    localparam int B_TX   = 7;
    localparam int B_RX   = 6;
    localparam int B_ACCV = 5;
    localparam int B_NMI  = 4;
    localparam int B_OSC  = 1;
    localparam int B_WDT  = 0;

    localparam logic [REG_W-1:0] EN_MASK  = 8'hF3;
    localparam logic [REG_W-1:0] FLG_MASK = 8'hD3;
    localparam logic [REG_W-1:0] FLG_RST  = 8'h82;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] REG_EN  = 2'd0;
    localparam logic [ADDR_W-1:0] REG_FLG = 2'd1;
endpackage

// File: rtl/irq_slot_map.sv
// Maps register state and request lines onto the sixteen priority slots.
// Assumes en_q/flg_q hold only implemented bits. Purely combinational.
module irq_slot_map
    import irq_vc_pkg::*;
(
    input  logic [REG_W-1:0]     en_q,
    input  logic [REG_W-1:0]     flg_q,
    input  logic                 rst_pend,
    input  logic                 gie,
    input  logic                 wdt_rst_mode,
    input  logic                 flash_viol,
    input  logic [NUM_SLOTS-1:0] periph_req,
    output logic [2:0]           nmi_src,
    output logic [NUM_SLOTS-1:0] slot_req
);
    logic [NUM_SLOTS-1:0] periph_lvl;

    // Contributors to the shared non-maskable slot: pin, oscillator, flash
    assign nmi_src[0] = en_q[B_NMI] & flg_q[B_NMI];
    assign nmi_src[1] = en_q[B_OSC] & flg_q[B_OSC];
    assign nmi_src[2] = en_q[B_ACCV] & flash_viol;

    // Outside peripheral levels, masked to the slots they may use
    assign periph_lvl = {NUM_SLOTS{gie}} & periph_req & PERIPH_MASK;

    genvar s;
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
        if (s == SLOT_RST) begin : g_rst
            assign slot_req[s] = rst_pend | periph_lvl[s];
        end else if (s == SLOT_NMI) begin : g_nmi
            assign slot_req[s] = (|nmi_src) | periph_lvl[s];
        end else if (s == SLOT_WDT) begin : g_wdt
            assign slot_req[s] = (gie & ~wdt_rst_mode & en_q[B_WDT] & flg_q[B_WDT])
                                 | periph_lvl[s];
        end else if (s == SLOT_RX) begin : g_rx
            assign slot_req[s] = (gie & en_q[B_RX] & flg_q[B_RX]) | periph_lvl[s];
        end else if (s == SLOT_TX) begin : g_tx
            assign slot_req[s] = (gie & en_q[B_TX] & flg_q[B_TX]) | periph_lvl[s];
        end else begin : g_per
            assign slot_req[s] = periph_lvl[s];
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Picks the highest pending slot and forms its vector word address.
// Assumes slot_req is valid each cycle; output is combinational.
module irq_prio_enc
    import irq_vc_pkg::*;
(
    input  logic                 clk,
    input  logic                 live,
    input  logic [NUM_SLOTS-1:0] slot_req,
    output logic                 req,
    output logic [IDX_W-1:0]     idx,
    output logic [VEC_W-1:0]     vec
);
    // Scan upward so the highest pending slot is the last one kept
    always_comb begin
        req = 1'b0;
        idx = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (slot_req[k]) begin
                req = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end

    // Vector word address grows by two bytes per priority step
    assign vec = VEC_BASE + (VEC_W'(idx) << 1);

    // R2
    top_slot_wins_chk: assert property (@(posedge clk) disable iff (!live)
        req |-> ((slot_req >> idx) == NUM_SLOTS'(1)));
endmodule

// File: rtl/irq_flag_regs.sv
// Enable and flag registers, the reset-slot latch, and acknowledge side effects.
// Assumes irq_ack is only pulsed while a request is shown, with ack_idx the shown slot.
module irq_flag_regs
    import irq_vc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              pinrst_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              wdt_rst_mode,
    input  logic              wdt_ovf_ev,
    input  logic              wdt_key_ev,
    input  logic              nmi_pin_ev,
    input  logic              osc_fault_ev,
    input  logic              ser_rx_ev,
    input  logic              ser_tx_ev,
    input  logic [2:0]        nmi_src,
    input  logic              irq_ack,
    input  logic [IDX_W-1:0]  ack_idx,
    output logic [REG_W-1:0]  en_q,
    output logic [REG_W-1:0]  flg_q,
    output logic              rst_pend
);
    logic             hard_rst, sys_rst, wr_en, wr_flg, armed;
    logic             ack_rst, ack_nmi;
    logic [REG_W-1:0] hw_set, ack_clr, en_clr, en_nxt, flg_nxt;

    assign hard_rst = !por_n || !pinrst_n;
    assign sys_rst  = hard_rst || !rst_n;
    assign wr_en    = bus_wr && (bus_addr == REG_EN);
    assign wr_flg   = bus_wr && (bus_addr == REG_FLG);
    assign ack_rst  = irq_ack && (ack_idx == IDX_W'(SLOT_RST));
    assign ack_nmi  = irq_ack && (ack_idx == IDX_W'(SLOT_NMI));

    // Hardware set events per flag bit
    always_comb begin
        hw_set         = '0;
        hw_set[B_TX]   = ser_tx_ev;
        hw_set[B_RX]   = ser_rx_ev;
        hw_set[B_NMI]  = nmi_pin_ev;
        hw_set[B_OSC]  = osc_fault_ev;
        hw_set[B_WDT]  = wdt_ovf_ev || wdt_key_ev;
    end

    // Flags auto-cleared by acknowledging a single-source slot
    always_comb begin
        ack_clr        = '0;
        ack_clr[B_WDT] = irq_ack && (ack_idx == IDX_W'(SLOT_WDT));
        ack_clr[B_RX]  = irq_ack && (ack_idx == IDX_W'(SLOT_RX));
        ack_clr[B_TX]  = irq_ack && (ack_idx == IDX_W'(SLOT_TX));
    end

    // Enables disarmed by an NMI-slot acknowledge, one per contributing source
    always_comb begin
        en_clr         = '0;
        en_clr[B_NMI]  = ack_nmi && nmi_src[0];
        en_clr[B_OSC]  = ack_nmi && nmi_src[1];
        en_clr[B_ACCV] = ack_nmi && nmi_src[2];
    end

    // Next-state: software write, then hardware set, then acknowledge clear
    assign en_nxt  = wr_en  ? (bus_wdata & EN_MASK)  : (en_q & ~en_clr);
    assign flg_nxt = wr_flg ? (bus_wdata & FLG_MASK)
                            : ((hw_set | (flg_q & ~ack_clr)) & FLG_MASK);

    // Enable register update
    always_ff @(posedge clk) begin
        if (sys_rst) en_q <= '0;
        else         en_q <= en_nxt;
    end

    // Flag register update; watchdog flag survives a soft reset
    always_ff @(posedge clk) begin
        if (sys_rst) begin
            flg_q <= FLG_RST;
            if (!hard_rst) flg_q[B_WDT] <= flg_q[B_WDT];
        end else begin
            flg_q <= flg_nxt;
        end
    end

    // Reset-slot latch: armed by any reset and by watchdog reset causes
    always_ff @(posedge clk) begin
        if (sys_rst)                                     rst_pend <= 1'b1;
        else if ((wdt_ovf_ev && wdt_rst_mode) || wdt_key_ev) rst_pend <= 1'b1;
        else if (ack_rst)                                rst_pend <= 1'b0;
    end

    // Register readback; unimplemented addresses read zero
    always_comb begin
        case (bus_addr)
            REG_EN:  bus_rdata = en_q;
            REG_FLG: bus_rdata = flg_q;
            default: bus_rdata = '0;
        endcase
    end

    // Checker arming after the first cycle out of power-on reset
    always_ff @(posedge clk) begin
        if (!por_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R12
    sw_write_wins_chk: assert property (@(posedge clk) disable iff (sys_rst)
        wr_flg |=> (flg_q == ($past(bus_wdata) & FLG_MASK)));

    // R5
    nmi_ack_disarm_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (ack_nmi && !wr_en && en_q[B_NMI] && flg_q[B_NMI]) |=> !en_q[B_NMI]);

    // R8
    wdt_flag_keep_chk: assert property (@(posedge clk) disable iff (!por_n || !armed)
        (!rst_n && pinrst_n) |=> (flg_q[B_WDT] == $past(flg_q[B_WDT])));

    // R3
    rst_slot_arm_chk: assert property (@(posedge clk) disable iff (sys_rst)
        ((wdt_ovf_ev && wdt_rst_mode) || wdt_key_ev) |=> rst_pend);
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the prioritized interrupt vector controller.
// Assumes the CPU pulses irq_ack for one cycle while irq_req is high.
module irq_vector_ctrl
    import irq_vc_pkg::*;
(
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 pinrst_n,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic                 gie,
    input  logic                 wdt_rst_mode,
    input  logic                 wdt_ovf_ev,
    input  logic                 wdt_key_ev,
    input  logic                 nmi_pin_ev,
    input  logic                 osc_fault_ev,
    input  logic                 flash_viol,
    input  logic                 ser_rx_ev,
    input  logic                 ser_tx_ev,
    input  logic [NUM_SLOTS-1:0] periph_req,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [IDX_W-1:0]     irq_idx,
    input  logic                 irq_ack
);
    logic [REG_W-1:0]     en_q, flg_q;
    logic                 rst_pend, live;
    logic [2:0]           nmi_src;
    logic [NUM_SLOTS-1:0] slot_req;

    assign live = por_n && pinrst_n && rst_n;

    irq_flag_regs u_regs (
        .clk(clk), .por_n(por_n), .pinrst_n(pinrst_n), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_rst_mode(wdt_rst_mode),
        .wdt_ovf_ev(wdt_ovf_ev), .wdt_key_ev(wdt_key_ev),
        .nmi_pin_ev(nmi_pin_ev), .osc_fault_ev(osc_fault_ev),
        .ser_rx_ev(ser_rx_ev), .ser_tx_ev(ser_tx_ev), .nmi_src(nmi_src),
        .irq_ack(irq_ack), .ack_idx(irq_idx),
        .en_q(en_q), .flg_q(flg_q), .rst_pend(rst_pend)
    );

    irq_slot_map u_map (
        .en_q(en_q), .flg_q(flg_q), .rst_pend(rst_pend), .gie(gie),
        .wdt_rst_mode(wdt_rst_mode), .flash_viol(flash_viol),
        .periph_req(periph_req), .nmi_src(nmi_src), .slot_req(slot_req)
    );

    irq_prio_enc u_prio (
        .clk(clk), .live(live), .slot_req(slot_req),
        .req(irq_req), .idx(irq_idx), .vec(irq_vec)
    );

    // R10
    gie_gate_chk: assert property (@(posedge clk) disable iff (!live)
        !gie |-> (!irq_req || (irq_idx >= IDX_W'(SLOT_NMI))));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, pinrst_n = 1'b1, rst_n = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic        gie = 1'b0, wdt_rst_mode = 1'b0;
    logic        wdt_ovf_ev = 1'b0, wdt_key_ev = 1'b0, nmi_pin_ev = 1'b0;
    logic        osc_fault_ev = 1'b0, flash_viol = 1'b0;
    logic        ser_rx_ev = 1'b0, ser_tx_ev = 1'b0;
    logic [15:0] periph_req = '0;
    logic        irq_req, irq_ack = 1'b0;
    logic [15:0] irq_vec;
    logic [3:0]  irq_idx;

    int n_chk = 0, n_fail = 0;

    irq_vector_ctrl u_dut (.*);

    always #10 clk = ~clk;

    // {gie, mode, accv, en[8], flag[8], periph[16], exp_req, exp_idx[4]}
    localparam int NV = 13;
    localparam logic [39:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,8'h00,8'h00,16'h0000,1'b0,4'd0},   // R2 idle
        {1'b1,1'b0,1'b0,8'h80,8'h80,16'h0000,1'b1,4'd8},   // R2 tx
        {1'b1,1'b0,1'b0,8'hC0,8'hC0,16'h0000,1'b1,4'd9},   // R2 rx over tx
        {1'b1,1'b0,1'b0,8'hC1,8'hC1,16'h0000,1'b1,4'd10},  // R9 interval mode
        {1'b1,1'b1,1'b0,8'hC1,8'hC1,16'h0000,1'b1,4'd9},   // R9 reset mode
        {1'b0,1'b0,1'b0,8'hC1,8'hC1,16'h0000,1'b0,4'd0},   // R10 gie off
        {1'b0,1'b0,1'b0,8'h10,8'h10,16'h0000,1'b1,4'd14},  // R4 nmi pin
        {1'b0,1'b0,1'b1,8'h20,8'h00,16'h0000,1'b1,4'd14},  // R4 flash
        {1'b1,1'b0,1'b0,8'h00,8'h00,16'h0001,1'b1,4'd0},   // R13 slot 0
        {1'b1,1'b0,1'b0,8'h00,8'h00,16'h2000,1'b1,4'd13},  // R13 slot 13
        {1'b1,1'b0,1'b0,8'h00,8'h00,16'hC700,1'b0,4'd0},   // R13 ignored bits
        {1'b1,1'b0,1'b0,8'h02,8'h02,16'h3800,1'b1,4'd14},  // R4 osc over periph
        {1'b1,1'b0,1'b0,8'h01,8'h01,16'h0800,1'b1,4'd11}   // R2 11 over 10
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        #1;
    endtask

    task automatic chk_irq(input string tag, input logic er, input int ei);
        #1;
        chk({tag, " req"}, irq_req, er);
        if (er) begin
            chk({tag, " idx"}, irq_idx, ei);
            chk({tag, " vec"}, irq_vec, 16'hFFE0 + 2 * ei);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        // R1 reset state
        rd(2'd0, r); chk("R1 enable", r, 8'h00);
        rd(2'd1, r); chk("R1 flag", r, 8'h82);
        chk_irq("R1 reset slot", 1'b1, 15);
        ack();
        chk_irq("R3 reset slot ack", 1'b0, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            gie = VEC[i][39]; wdt_rst_mode = VEC[i][38]; flash_viol = VEC[i][37];
            periph_req = VEC[i][20:5];
            wr(2'd0, VEC[i][36:29]);
            wr(2'd1, VEC[i][28:21]);
            chk_irq($sformatf("R2 table %0d", i), VEC[i][4], VEC[i][3:0]);
        end
        periph_req = '0; flash_viol = 1'b0; wdt_rst_mode = 1'b0; gie = 1'b0;

        // R6 unimplemented bits
        wr(2'd0, 8'hFF); rd(2'd0, r); chk("R6 enable mask", r, 8'hF3);
        wr(2'd1, 8'hFF); rd(2'd1, r); chk("R6 flag mask", r, 8'hD3);
        wr(2'd2, 8'hFF); rd(2'd2, r); chk("R6 other addr", r, 8'h00);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);

        // R7 event pulses
        ser_tx_ev = 1'b1; @(negedge clk); ser_tx_ev = 1'b0;
        rd(2'd1, r); chk("R7 tx flag", r, 8'h80);
        ser_rx_ev = 1'b1; @(negedge clk); ser_rx_ev = 1'b0;
        rd(2'd1, r); chk("R7 rx flag", r, 8'hC0);
        nmi_pin_ev = 1'b1; @(negedge clk); nmi_pin_ev = 1'b0;
        rd(2'd1, r); chk("R7 nmi flag", r, 8'hD0);
        osc_fault_ev = 1'b1; @(negedge clk); osc_fault_ev = 1'b0;
        rd(2'd1, r); chk("R7 osc flag", r, 8'hD2);
        wdt_ovf_ev = 1'b1; @(negedge clk); wdt_ovf_ev = 1'b0;
        rd(2'd1, r); chk("R7 wdt flag", r, 8'hD3);
        chk_irq("R3 interval overflow no reset", 1'b0, 0);

        // R8 watchdog flag across resets
        rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(2'd1, r); chk("R8 soft reset keeps wdt", r, 8'h83);
        rd(2'd0, r); chk("R1 soft reset enable", r, 8'h00);
        chk_irq("R1 soft reset slot", 1'b1, 15);
        ack();
        pinrst_n = 1'b0; repeat (2) @(negedge clk); pinrst_n = 1'b1;
        rd(2'd1, r); chk("R8 pin reset clears wdt", r, 8'h82);
        ack();

        // R3 reset-slot causes
        wdt_rst_mode = 1'b1;
        wdt_ovf_ev = 1'b1; @(negedge clk); wdt_ovf_ev = 1'b0;
        chk_irq("R3 overflow reset mode", 1'b1, 15);
        ack(); chk_irq("R3 after ack", 1'b0, 0);
        wdt_rst_mode = 1'b0;
        wdt_key_ev = 1'b1; @(negedge clk); wdt_key_ev = 1'b0;
        chk_irq("R3 key violation", 1'b1, 15);
        ack();

        // R9 watchdog enable honoured only in interval mode
        gie = 1'b1;
        wr(2'd0, 8'h01); wr(2'd1, 8'h01);
        chk_irq("R9 interval", 1'b1, 10);
        wdt_rst_mode = 1'b1; chk_irq("R9 reset mode", 1'b0, 0);
        wdt_rst_mode = 1'b0; #1;

        // R11 acknowledge auto-clear
        ack(); rd(2'd1, r); chk("R11 wdt flag cleared", r, 8'h00);
        wr(2'd0, 8'hC0); wr(2'd1, 8'hC0);
        chk_irq("R11 rx first", 1'b1, 9);
        ack(); rd(2'd1, r); chk("R11 rx cleared", r, 8'h80);
        chk_irq("R11 tx next", 1'b1, 8);
        ack(); rd(2'd1, r); chk("R11 tx cleared", r, 8'h00);
        wr(2'd0, 8'h00); periph_req = 16'h0010;
        chk_irq("R11 periph slot", 1'b1, 4);
        ack(); chk_irq("R11 periph still held", 1'b1, 4);
        rd(2'd1, r); chk("R11 periph ack flags", r, 8'h00);
        periph_req = '0;

        // R5 NMI acknowledge disarms contributors only
        gie = 1'b0;
        wr(2'd0, 8'h33); wr(2'd1, 8'h12);
        chk_irq("R5 nmi slot", 1'b1, 14);
        ack();
        rd(2'd0, r); chk("R5 enables after ack", r, 8'h21);
        rd(2'd1, r); chk("R5 flags kept", r, 8'h12);
        chk_irq("R5 no re-entry", 1'b0, 0);

        // R12 software write beats hardware set
        ser_rx_ev = 1'b1;
        wr(2'd1, 8'h00);
        ser_rx_ev = 1'b0;
        rd(2'd1, r); chk("R12 write wins", r, 8'h00);

        finish_run();
    end
endmodule